// File: doc/BRIEF.md
# Teletext Request Window Generator

This block drives a single request strobe once per video line. The strobe tells an upstream teletext source to supply data bits while it is high. A line-start pulse sets the timing reference. A nominal window opens `NOM_START` clocks after that pulse and is `NOM_LEN` clocks long. An 8-bit control byte moves the two edges of the window independently. The upper nibble delays the rising edge. The lower nibble pulls the falling edge earlier, which shortens the window and so reduces the number of bits requested.

If the lower nibble is zero, the falling edge moves with the rising edge and the window keeps its nominal width. The control byte is captured only on the line-start pulse, so a window cannot change shape partway through a line. An enable input gates the strobe at once. An output counter reports how many clocks the strobe was high on the current line.

The block is built around a four-state machine:
- `ST_OFF`: disabled, or waiting for the first line.
- `ST_LEAD`: counting toward the rising edge.
- `ST_ACTIVE`: the request is high.
- `ST_DONE`: the window is over and the block waits for the next line.

Its transitions are:
- `go_line`: from any state, on a line pulse with enable high, to `ST_LEAD`.
- `open`: from `ST_LEAD` to `ST_ACTIVE` when the rising edge is reached.
- `skip`: from `ST_LEAD` to `ST_DONE` when the window is empty.
- `close`: from `ST_ACTIVE` to `ST_DONE` at the falling edge.
- `kill`: from any state to `ST_OFF` when enable is low.

Top module: `ttx_req_window`

## Requirements
- R1: After reset, `req_o` is 0 and `req_cnt_o` is 0.
- R2: Let the line pulse be sampled at clock edge 0 and let k count clock edges after it. The rising edge of `req_o` then falls in cycle k = S, where S = NOM_START + ctrl[7:4].
- R3: When ctrl[3:0] is non-zero, the falling-edge position is E = NOM_START + NOM_LEN − ctrl[3:0]. This is measured from the nominal end, not from S. `req_o` is high for every cycle S ≤ k < E.
- R4: When ctrl[3:0] is zero, E = S + NOM_LEN, so the window width is NOM_LEN for every value of ctrl[7:4].
- R5: When E ≤ S, `req_o` stays low for the whole line.
- R6: `req_o` drops in the same cycle that `en_i` goes low. It stays low for the rest of that line even if `en_i` returns, and the window resumes with the next line pulse that is sampled with `en_i` high.
- R7: `ctrl_i` is sampled only at a line pulse. Changes made between pulses do not affect the current line's window.
- R8: `req_cnt_o` is cleared at each line pulse and then adds one for every clock in which `req_o` was high. At the end of a line it holds the number of request cycles on that line.
- R9: A line pulse that arrives during a window restarts the timing from that pulse, using the control byte present at the new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_start_i | input | 1 | One-cycle line-start timing pulse |
| en_i | input | 1 | Request enable; low forces the request off at once |
| ctrl_i | input | 8 | [7:4] rising-edge delay, [3:0] falling-edge advance |
| req_o | output | 1 | Teletext request strobe |
| req_cnt_o | output | CNT_W | Request cycles counted since the last line pulse |

## Verification
The bench compares every cycle of each line against windows computed from the two nibbles. It covers these corner cases:
- A zero falling field combined with rising delays up to 15. A design that measured a zero advance from the nominal end would shrink the window instead of shifting it.
- Nibble pairs where the end falls at or before the start. A design that missed this case would raise the request for a wrap-around length.
- Control changes made mid-line, and enable dropped and restored mid-window. A design that sampled the byte late, or re-armed on enable, would show a moved or reopened window.
- Line pulses that cut a window short. The bench checks that timing restarts from the new pulse and that the cycle counter tallies exactly the high cycles.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_LEAD   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_DONE   = 2'd3
    } ttx_state_e;
endpackage

// File: rtl/ttx_ctrl_latch.sv
module ttx_ctrl_latch
    import ttx_req_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [7:0]       ctrl_i,
    output logic [NIB_W-1:0] rise_o,
    output logic [NIB_W-1:0] fall_o
);
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rise_o <= '0;
            fall_o <= '0;
        end else if (load_i) begin
            rise_o <= ctrl_i[7:4];
            fall_o <= ctrl_i[3:0];
        end
    end

    // R7: the captured nibbles move only on a line pulse
    a_r7_hold_between_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($stable(rise_o) && $stable(fall_o)));
endmodule

// File: rtl/ttx_edge_calc.sv
module ttx_edge_calc
    import ttx_req_pkg::*;
#(
    parameter int NOM_START = 12,
    parameter int NOM_LEN   = 360,
    parameter int POS_W     = 9
) (
    input  logic [NIB_W-1:0] rise_i,
    input  logic [NIB_W-1:0] fall_i,
    output logic [POS_W-1:0] start_o,
    output logic [POS_W-1:0] end_o,
    output logic             empty_o
);
    localparam logic [POS_W-1:0] BASE  = POS_W'(NOM_START);
    localparam logic [POS_W-1:0] NOMEND = POS_W'(NOM_START + NOM_LEN);

    always_comb begin
        start_o = BASE + POS_W'(rise_i);
        if (fall_i == '0) begin
            end_o = NOMEND + POS_W'(rise_i);
        end else begin
            end_o = NOMEND - POS_W'(fall_i);
        end
        empty_o = (end_o <= start_o);
    end
endmodule

// File: rtl/ttx_req_counter.sv
module ttx_req_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R8: a line pulse empties the tally
    a_r8_clear_on_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_o == '0));
    // R8: idle cycles leave the tally alone
    a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/ttx_req_window.sv
module ttx_req_window
    import ttx_req_pkg::*;
#(
    parameter int NOM_START = 12,
    parameter int NOM_LEN   = 360,
    parameter int CNT_W     = $clog2(NOM_LEN + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_start_i,
    input  logic             en_i,
    input  logic [7:0]       ctrl_i,
    output logic             req_o,
    output logic [CNT_W-1:0] req_cnt_o
);
    localparam int POS_W = $clog2(NOM_START + NOM_LEN + 17);

    ttx_state_e        state_q, state_d;
    logic [POS_W-1:0]  pos_q, pos_inc;
    logic [POS_W-1:0]  start_pos, end_pos;
    logic              empty_win;
    logic [NIB_W-1:0]  rise_q, fall_q;
    logic              line_go;

    assign line_go = line_start_i && en_i;
    assign pos_inc = pos_q + 1'b1;

    ttx_ctrl_latch u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (line_go),
        .ctrl_i (ctrl_i),
        .rise_o (rise_q),
        .fall_o (fall_q)
    );

    ttx_edge_calc #(
        .NOM_START (NOM_START),
        .NOM_LEN   (NOM_LEN),
        .POS_W     (POS_W)
    ) u_edges (
        .rise_i  (rise_q),
        .fall_i  (fall_q),
        .start_o (start_pos),
        .end_o   (end_pos),
        .empty_o (empty_win)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_OFF;                       // kill
        end else if (line_start_i) begin
            state_d = ST_LEAD;                      // go_line
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_OFF;
                ST_LEAD:   if (pos_inc == start_pos)
                               state_d = empty_win ? ST_DONE : ST_ACTIVE;  // skip / open
                ST_ACTIVE: if (pos_inc == end_pos) state_d = ST_DONE;      // close
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // state and position registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            if (line_go) begin
                pos_q <= '0;
            end else if (state_q == ST_LEAD || state_q == ST_ACTIVE) begin
                pos_q <= pos_inc;
            end
        end
    end

    // outputs
    always_comb begin
        req_o = (state_q == ST_ACTIVE) && en_i;
    end

    ttx_req_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (line_go),
        .inc_i  (req_o),
        .cnt_o  (req_cnt_o)
    );

    // R6: enable low silences the strobe in the same cycle
    a_r6_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !req_o);
    // R2: never high before the rising edge position
    a_r2_not_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (pos_q >= start_pos));
    // R3: never high at or past the falling edge position
    a_r3_stop_by_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (pos_q < end_pos));
    // R5: an empty window never reaches the active state
    a_r5_empty_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE) |-> !empty_win);
    // R9: a line pulse always restarts in the lead state
    a_r9_restart_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_go |=> (state_q == ST_LEAD && pos_q == '0));
endmodule

// File: tb/ttx_req_window_tb_top.sv
module ttx_req_window_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 4;
    localparam int NL   = 24;
    localparam int CW   = $clog2(NL + 1);
    localparam int LINE = NS + NL + 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_start = 1'b0;
    logic          en = 1'b1;
    logic [7:0]    ctrl = 8'h00;
    logic          req;
    logic [CW-1:0] cnt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ttx_req_window #(.NOM_START(NS), .NOM_LEN(NL), .CNT_W(CW)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .line_start_i (line_start),
        .en_i         (en),
        .ctrl_i       (ctrl),
        .req_o        (req),
        .req_cnt_o    (cnt)
    );

    function automatic int exp_start(logic [7:0] c);
        return NS + int'(c[7:4]);
    endfunction

    function automatic int exp_end(logic [7:0] c);
        if (c[3:0] == 4'h0) return NS + NL + int'(c[7:4]);
        return NS + NL - int'(c[3:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One line: pulse with byte c, optional mid-line byte change, optional
    // enable drop at k=drop and restore at k=reen, length len cycles.
    task automatic run_line(input logic [7:0] c, input bit chg, input int drop,
                            input int reen, input int len, input string tag);
        int s = exp_start(c);
        int e = exp_end(c);
        int first_bad = -1;
        int bad_act = 0;
        int ecount = 0;
        bit off = 1'b0;
        @(negedge clk);
        line_start = 1'b1;
        ctrl = c;
        en = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            if (chg && k == 2) ctrl = ~c;           // R7 stimulus
            if (k == drop) begin en = 1'b0; off = 1'b1; end
            if (k == reen) en = 1'b1;
            #1;
            begin
                bit exp_req = !off && (k >= s) && (k < e);
                if (exp_req) ecount++;
                if (req !== exp_req && first_bad < 0) begin
                    first_bad = k;
                    bad_act = int'(req);
                end
            end
        end
        chk(first_bad < 0, {tag, " window shape"}, first_bad, -1);
        if (len == LINE) begin
            @(negedge clk); #1;
            chk(cnt == CW'(ecount), {tag, " R8 count"}, int'(cnt), ecount);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        #1;
        chk(req === 1'b0, "R1 req after reset", int'(req), 0);
        chk(cnt === '0, "R1 count after reset", int'(cnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req === 1'b0, "R1 req idle before first line", int'(req), 0);

        run_line(8'h00, 0, -1, -1, LINE, "R2 R4 nominal");
        run_line(8'hF0, 0, -1, -1, LINE, "R2 R4 max rise, zero fall tracks");
        run_line(8'h70, 0, -1, -1, LINE, "R4 mid rise tracks");
        run_line(8'h05, 0, -1, -1, LINE, "R3 fall advance");
        run_line(8'h3F, 0, -1, -1, LINE, "R3 max fall");
        run_line(8'hF9, 0, -1, -1, LINE, "R5 empty end==start");
        run_line(8'hFF, 0, -1, -1, LINE, "R5 empty end<start");
        run_line(8'h42, 1, -1, -1, LINE, "R7 mid-line byte change");
        run_line(8'h21, 0, NS + 6, NS + 9, LINE, "R6 drop and restore");
        run_line(8'h21, 0, -1, -1, LINE, "R6 resumes next line");
        run_line(8'h30, 0, 1, -1, LINE, "R6 drop before window");
        run_line(8'h00, 0, -1, -1, NS + 5, "R9 cut short");
        run_line(8'hA3, 0, -1, -1, LINE, "R9 restarted line");

        for (int i = 0; i < 40; i++) begin
            logic [7:0] c = 8'($urandom);
            int d = ($urandom % 4 == 0) ? int'($urandom % LINE) : -1;
            int r = (d >= 0) ? d + 1 + int'($urandom % 5) : -1;
            bit g = ($urandom % 3 == 0);
            run_line(c, g, d, r, LINE, "R2 R3 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule